// File: doc/BRIEF.md
# Secure FIQ Interrupt Routing Controller

This block receives a bus of level-sensitive interrupt sources and, for each line, decides under software control whether it goes to a plain IRQ pass-through bus or into a fast-interrupt (FIQ) path. Lines placed in the FIQ path are gated by a per-line enable mask. The gated lines are OR-reduced into one active-low FIQ output for the processor. Lines left in the pass-through group appear unchanged on the IRQ bus for a downstream controller.

Software programs the block through a single-cycle register port: an address, a write strobe, write data and combinational read data. The enable mask is changed only through two registers. One register sets enable bits and the other clears them, so no read-modify-write sequence is needed. A bypass control can hand the FIQ output to an external active-low non-secure FIQ input. This lets another interrupt controller drive the processor pin directly.

Top module: `fiq_route_ctrl`

## Requirements
- R1: After reset the route-select mask, the enable mask and the bypass bit are all zero. fiq_n_o is 1 and irq_pass_o equals src_i.
- R2: For every line, irq_pass_o[i] = src_i[i] & ~select[i]. A line that has been routed to the FIQ path never shows on irq_pass_o.
- R3: The route-select register is at byte offset 0x08. It is read/write and 32 bits wide, one bit per source. A bit value of 1 places that source in the FIQ path.
- R4: Writing to offset 0x0C sets each enable bit whose write-data bit is 1. A write-data bit of 0 leaves that enable bit unchanged. A read of 0x0C returns the current enable mask.
- R5: Writing to offset 0x10 clears each enable bit whose write-data bit is 1. A write-data bit of 0 leaves that enable bit unchanged. A read of 0x10 returns zero.
- R6: While bypass is 0, fiq_n_o is 0 exactly when some line has src_i, select and enable all 1, and is 1 otherwise.
- R7: The bypass bit is bit 0 of offset 0x14. While it is 1, fiq_n_o follows nsfiq_n_i. A read of 0x14 returns zero in bits 31:1.
- R8: A read of offset 0x00 returns src_i. A write to 0x00 changes no register. A read of any unmapped offset (for example 0x04) returns zero.
- R9: A write takes effect at the clock edge that samples it and not before. If a set write and a clear write of the same bit come on consecutive cycles, they apply in the order they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level interrupt sources |
| nsfiq_n_i | input | 1 | External non-secure FIQ, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_pass_o | output | 32 | IRQ pass-through bus |
| fiq_n_o | output | 1 | FIQ to the processor, active low |

## Verification
The bench writes zero to the set register and to the clear register. A design that treats those registers as plain stores would lose the enable mask, and the following read of 0x0C would show this. It issues a set and a clear of the same bit on back-to-back cycles and samples between them. A design that applies the writes out of order, or too early, would either keep the bit or never show the FIQ assertion. It moves a line between groups and toggles the external FIQ with bypass on and off. This exposes a leaky pass-through mask, a missing enable gate, or a bypass mux that inverts the external input or ignores it.

// File: rtl/fiq_route_pkg.sv
package fiq_route_pkg;
  localparam int unsigned SRC_W  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RAW  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SEL  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ENS  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ENC  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_BYP  = 8'h14;

  typedef struct packed {
    logic [SRC_W-1:0] sel;
    logic [SRC_W-1:0] en;
    logic             byp;
  } route_cfg_t;
endpackage

// File: rtl/fiq_route_regs.sv
module fiq_route_regs
  import fiq_route_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_W,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] raw_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  output route_cfg_t       cfg_o
);
  logic [N_SRC-1:0] sel_q, en_q;
  logic             byp_q;

  // decoded write events, brought out for the assertions
  logic wr_sel, wr_set, wr_clr, wr_byp;
  assign wr_sel = we_i && (addr_i == AW'(OFS_SEL));
  assign wr_set = we_i && (addr_i == AW'(OFS_ENS));
  assign wr_clr = we_i && (addr_i == AW'(OFS_ENC));
  assign wr_byp = we_i && (addr_i == AW'(OFS_BYP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      byp_q <= 1'b0;
    end else begin
      if (wr_sel) sel_q <= wdata_i;
      if (wr_byp) byp_q <= wdata_i[0];
    end
  end

  for (genvar i = 0; i < int'(N_SRC); i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       en_q[i] <= 1'b0;
      else if (wr_set && wdata_i[i])    en_q[i] <= 1'b1;
      else if (wr_clr && wdata_i[i])    en_q[i] <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      AW'(OFS_RAW): rdata_o = raw_i;
      AW'(OFS_SEL): rdata_o = sel_q;
      AW'(OFS_ENS): rdata_o = en_q;
      AW'(OFS_BYP): rdata_o = {{(N_SRC-1){1'b0}}, byp_q};
      default:      rdata_o = '0;
    endcase
  end

  assign cfg_o.sel = sel_q;
  assign cfg_o.en  = en_q;
  assign cfg_o.byp = byp_q;

  p_set_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));
  p_set_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(en_q)) == $past(en_q)));
  p_clr_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(wdata_i)) == '0));
  p_clr_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q | $past(en_q)) == $past(en_q)));
  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(en_q));
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(sel_q));
endmodule

// File: rtl/fiq_route_merge.sv
module fiq_route_merge
  import fiq_route_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_W
) (
  input  logic [N_SRC-1:0] raw_i,
  input  route_cfg_t       cfg_i,
  input  logic             nsfiq_n_i,
  output logic [N_SRC-1:0] irq_pass_o,
  output logic             fiq_req_o,
  output logic             fiq_n_o
);
  function automatic logic [N_SRC-1:0] pass_mask(input logic [N_SRC-1:0] r,
                                                 input logic [N_SRC-1:0] s);
    return r & ~s;
  endfunction

  function automatic logic fiq_any(input logic [N_SRC-1:0] r,
                                   input logic [N_SRC-1:0] s,
                                   input logic [N_SRC-1:0] e);
    return |(r & s & e);
  endfunction

  assign irq_pass_o = pass_mask(raw_i, cfg_i.sel);
  assign fiq_req_o  = fiq_any(raw_i, cfg_i.sel, cfg_i.en);
  assign fiq_n_o    = cfg_i.byp ? nsfiq_n_i : ~fiq_req_o;
endmodule

// File: rtl/fiq_route_ctrl.sv
module fiq_route_ctrl
  import fiq_route_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_W,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             nsfiq_n_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_we_i,
  input  logic [N_SRC-1:0] reg_wdata_i,
  output logic [N_SRC-1:0] reg_rdata_o,
  output logic [N_SRC-1:0] irq_pass_o,
  output logic             fiq_n_o
);
  route_cfg_t cfg;
  logic       fiq_req;

  fiq_route_regs #(.N_SRC(N_SRC), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .raw_i(src_i), .addr_i(reg_addr_i),
    .we_i(reg_we_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .cfg_o(cfg)
  );

  fiq_route_merge #(.N_SRC(N_SRC)) u_merge (
    .raw_i(src_i), .cfg_i(cfg), .nsfiq_n_i(nsfiq_n_i),
    .irq_pass_o(irq_pass_o), .fiq_req_o(fiq_req), .fiq_n_o(fiq_n_o)
  );

  p_no_leak_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pass_o & cfg.sel) == '0);
  p_pass_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pass_o & ~src_i) == '0);
  p_fiq_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.byp && fiq_req) |-> !fiq_n_o);
  p_fiq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.byp && ((src_i & cfg.sel & cfg.en) == '0)) |-> fiq_n_o);
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.byp |-> (fiq_n_o == nsfiq_n_i));
endmodule

// File: tb/tb_fiq_route_ctrl.sv
module tb_fiq_route_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        nsfiq_n = 1'b1;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, irq_pass;
  logic        fiq_n;

  always #4 clk = ~clk; // 125 MHz

  fiq_route_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .nsfiq_n_i(nsfiq_n),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_pass_o(irq_pass), .fiq_n_o(fiq_n)
  );

  // bench-side model built from the requirements
  logic [31:0] m_sel = '0, m_en = '0;
  logic        m_byp = 1'b0;

  // scoreboard: 0 = read data, 1 = irq bus, 2 = fiq pin
  int          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic push(input int k, input logic [31:0] e, input string t);
    q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return src;
      8'h08: return m_sel;
      8'h0C: return m_en;
      8'h14: return {31'b0, m_byp};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_fiq();
    return m_byp ? nsfiq_n : ~(|(src & m_sel & m_en));
  endfunction

  // expect read of addr a, plus the routing outputs
  task automatic expect_all(input logic [7:0] a, input string t);
    addr = a;
    push(0, exp_rd(a), t);
    push(1, src & ~m_sel, t);
    push(2, {31'b0, exp_fiq()}, t);
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
    case (a)
      8'h08: m_sel = d;
      8'h0C: m_en = m_en | d;
      8'h10: m_en = m_en & ~d;
      8'h14: m_byp = d[0];
      default: ;
    endcase
  endtask

  // monitor
  always @(negedge clk) begin
    while (q_kind.size() > 0) begin
      int k; logic [31:0] e, a; string t;
      k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
      a = (k == 0) ? rdata : (k == 1) ? irq_pass : {31'b0, fiq_n};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    src = 32'hA5A5_0F0F;
    // R1 reset state
    expect_all(8'h08, "R1 sel");
    expect_all(8'h0C, "R1 en");
    expect_all(8'h14, "R1 byp");
    // R2/R3 route low half to FIQ path
    wr(8'h08, 32'h0000_FFFF);
    expect_all(8'h08, "R3 sel rw");
    expect_all(8'h00, "R2 pass mask");
    // R4 set, zero writes have no effect, accumulation
    wr(8'h0C, 32'h0000_0003);
    expect_all(8'h0C, "R6 fiq asserted");
    wr(8'h0C, 32'h0);
    expect_all(8'h0C, "R4 zero no effect");
    wr(8'h0C, 32'h0000_0004);
    expect_all(8'h0C, "R4 accumulate");
    // R5 clear
    wr(8'h10, 32'h0000_0001);
    expect_all(8'h0C, "R5 clear bit0");
    wr(8'h10, 32'h0);
    expect_all(8'h0C, "R5 zero no effect");
    expect_all(8'h10, "R5 read zero");
    // R6 selected but disabled line
    src = 32'h0000_0100;
    expect_all(8'h00, "R6 disabled line");
    // R9 back-to-back set then clear of bit 8
    @(posedge clk); #1;
    addr = 8'h0C; wdata = 32'h100; we = 1'b1;
    @(posedge clk); #1;
    addr = 8'h10; m_en = m_en | 32'h100;
    push(2, {31'b0, exp_fiq()}, "R9 set visible");
    @(posedge clk); #1;
    we = 1'b0; m_en = m_en & ~32'h100;
    expect_all(8'h0C, "R9 clear after set");
    // R7 bypass
    wr(8'h14, 32'hFFFF_FFFF);
    expect_all(8'h14, "R7 bypass read");
    nsfiq_n = 1'b0;
    expect_all(8'h14, "R7 follow low");
    nsfiq_n = 1'b1; src = 32'h0000_0002;
    expect_all(8'h14, "R7 follow high");
    // R8 raw view and unmapped
    wr(8'h00, 32'hFFFF_FFFF);
    src = 32'h1234_5678;
    expect_all(8'h00, "R8 raw read");
    expect_all(8'h04, "R8 unmapped");
    expect_all(8'h08, "R8 raw write ignored");
    // bypass off, FIQ back from internal path
    wr(8'h14, 32'h0);
    src = 32'h0000_0006;
    expect_all(8'h14, "R6 internal again");
    src = 32'hFFFF_0000;
    expect_all(8'h00, "R2 upper pass");
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule